// File: doc/BRIEF.md
# Buffered SPI Target with Status Flags

This block is the target (slave) end of a full-duplex SPI link in mode 3: the serial clock idles high, the outgoing bit changes on the falling edge and the incoming bit is captured on the rising edge, most significant bit first. Frames are 8 bits long. SCK, MOSI and the active-low select are brought into the system clock domain through two-flop synchronizers. The block then finds the clock edges on the system clock.

On the host side there is one data register. A write strobe loads the one-entry transmit buffer. A read strobe consumes the one-entry receive buffer, whose value is always presented on `rd_data`. Because both buffers sit in front of the shift logic, the host can load the next byte while the current frame is still shifting, and frames then run with no idle gap.

The host sees four flags:
- `txe`: the transmit buffer is free.
- `rxne`: a received byte is waiting.
- `bsy`: a frame is in flight, or a byte is queued.
- `ovr`: a sticky overrun indication.

A clean stop waits for `rxne`, then `txe`, then a low `bsy`, and then reads the last byte.

Top module: `spi_tgt_buffered`

## Requirements
- R1: Mode 3, MSB first: `miso` presents bit 7 of the loaded byte after the first falling SCK edge of a frame and the next lower bit after each later falling edge; `mosi` is captured on each rising edge, and the first captured bit becomes bit 7 of the received byte.
- R2: A frame is 8 rising edges long; the falling edge that follows the 8th rising edge starts the next frame with no idle cycle required, and both frames are received and transmitted correctly.
- R3: `txe` is 1 after reset, goes to 0 on a `wr_en` pulse, and returns to 1 when the buffered byte moves into the shifter at the start of a frame.
- R4: When a frame completes while `rxne` is 0, the byte is placed on `rd_data` and `rxne` goes to 1; an `rd_en` pulse clears `rxne`.
- R5: `bsy` is 1 from the first falling edge of a frame until it completes; at completion it falls to 0 when `txe` is 1 and stays 1 when a byte is queued; deasserting `cs_n` forces it to 0.
- R6: A byte written while a frame is shifting (after that frame's start) is sent in the very next frame.
- R7: A frame that completes while `rxne` is 1 sets `ovr` and leaves `rd_data` at the older byte; `ovr` stays set until an `rd_en` pulse is followed later by a `stat_rd` pulse, and `stat_rd` alone does not clear it.
- R8: If a frame starts while `txe` is 1, the last byte moved into the shifter is sent again (0x00 if none since reset), and `txe` stays 1.
- R9: Raising `cs_n` before the 8th rising edge drops the partial frame: `rxne` and `rd_data` are unchanged, and the next full frame is received from its own first bit.
- R10: After reset, `txe`=1, `rxne`=0, `bsy`=0, `ovr`=0 and `rd_data`=0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the controller, idles high |
| cs_n | input | 1 | Active-low target select |
| mosi | input | 1 | Serial data from the controller |
| miso | output | 1 | Serial data to the controller |
| wr_en | input | 1 | Data register write strobe |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Data register read strobe |
| rd_data | output | 8 | Receive buffer contents |
| stat_rd | input | 1 | Status register read strobe |
| txe | output | 1 | Transmit buffer empty |
| rxne | output | 1 | Receive buffer not empty |
| bsy | output | 1 | Frame in flight or byte queued |
| ovr | output | 1 | Sticky receive overrun |

## Verification
The bench builds the block with its defaults: 8-bit frames and two synchronizer stages. SCK runs at eight system clocks per half period, so an edge settles through the synchronizer and the edge detector well before the opposite edge arrives. This allows a controller model that keeps SCK going without a break from one frame to the next. Host writes and reads can land in the middle of a frame, which is needed for the gap-free handoff, the overrun and the repeat-on-underrun cases.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;
    localparam int unsigned FRAME_W  = 8;
    localparam int unsigned SYNC_LEN = 2;

    // synchronized serial-side view
    typedef struct packed {
        logic sck;
        logic mosi;
        logic cs_n;
    } pins_t;
endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rst_val,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q[g] <= rst_val;
                else if (g == 0) st_q[g] <= d;
                else st_q[g] <= st_q[(g == 0) ? 0 : g - 1];
            end
        end
    endgenerate

    assign q = st_q[STAGES-1];
endmodule

// File: rtl/spi_tgt_shift.sv
module spi_tgt_shift #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_act,
    input  logic          sck_fall,
    input  logic          sck_rise,
    input  logic          mosi_s,
    input  logic [DW-1:0] load_byte,
    output logic          frame_start,
    output logic          frame_done,
    output logic [DW-1:0] rx_byte,
    output logic          miso
);
    localparam int unsigned CW = (DW > 1) ? $clog2(DW) : 1;

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
        logic [DW-1:0] tx_sh;
        logic [DW-1:0] rx_sh;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d        = sh_q;
        frame_start = 1'b0;
        frame_done  = 1'b0;
        rx_byte     = {sh_q.rx_sh[DW-2:0], mosi_s};
        if (!cs_act) begin
            sh_d.active = 1'b0;
            sh_d.cnt    = '0;
        end else begin
            if (sck_fall) begin
                if (!sh_q.active) begin
                    frame_start = 1'b1;
                    sh_d.active = 1'b1;
                    sh_d.cnt    = '0;
                    sh_d.tx_sh  = load_byte;
                end else begin
                    sh_d.tx_sh = {sh_q.tx_sh[DW-2:0], 1'b0};
                end
            end
            if (sck_rise && sh_q.active) begin
                sh_d.rx_sh = rx_byte;
                if (sh_q.cnt == CW'(DW - 1)) begin
                    frame_done  = 1'b1;
                    sh_d.active = 1'b0;
                    sh_d.cnt    = '0;
                end else begin
                    sh_d.cnt = sh_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign miso = sh_q.tx_sh[DW-1];
endmodule

// File: rtl/spi_tgt_buffered.sv
module spi_tgt_buffered
    import spi_tgt_pkg::*;
#(
    parameter int unsigned DW       = FRAME_W,
    parameter int unsigned SYNC_STG = SYNC_LEN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck,
    input  logic          cs_n,
    input  logic          mosi,
    output logic          miso,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    input  logic          stat_rd,
    output logic          txe,
    output logic          rxne,
    output logic          bsy,
    output logic          ovr
);
    localparam int unsigned PW = $bits(pins_t);

    pins_t pins_s;
    logic  sck_prev_q;
    logic  sck_rise, sck_fall, cs_act;

    spi_tgt_sync #(.W(PW), .STAGES(SYNC_STG)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_val (PW'(3'b101)),
        .d       ({sck, mosi, cs_n}),
        .q       (pins_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_prev_q <= 1'b1;
        else        sck_prev_q <= pins_s.sck;
    end

    assign sck_rise = pins_s.sck & ~sck_prev_q;
    assign sck_fall = ~pins_s.sck & sck_prev_q;
    assign cs_act   = ~pins_s.cs_n;

    typedef struct packed {
        logic [DW-1:0] txbuf;
        logic [DW-1:0] last;
        logic [DW-1:0] rxbuf;
        logic          txe;
        logic          rxne;
        logic          bsy;
        logic          ovr;
        logic          ovr_arm;
    } hs_t;

    hs_t hs_d, hs_q;

    logic          f_start, f_done;
    logic [DW-1:0] f_rx, load_byte;

    assign load_byte = hs_q.txe ? hs_q.last : hs_q.txbuf;

    spi_tgt_shift #(.DW(DW)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_act      (cs_act),
        .sck_fall    (sck_fall),
        .sck_rise    (sck_rise),
        .mosi_s      (pins_s.mosi),
        .load_byte   (load_byte),
        .frame_start (f_start),
        .frame_done  (f_done),
        .rx_byte     (f_rx),
        .miso        (miso)
    );

    always_comb begin
        hs_d = hs_q;
        // transmit side: buffer handoff at frame start, then host write
        if (f_start) begin
            hs_d.bsy = 1'b1;
            if (!hs_q.txe) begin
                hs_d.last = hs_q.txbuf;
                hs_d.txe  = 1'b1;
            end
        end
        if (wr_en) begin
            hs_d.txbuf = wr_data;
            hs_d.txe   = 1'b0;
        end
        // receive side: host read is taken before a completing frame
        if (rd_en) begin
            hs_d.rxne = 1'b0;
            if (hs_q.ovr) hs_d.ovr_arm = 1'b1;
        end
        if (stat_rd && hs_q.ovr_arm) begin
            hs_d.ovr     = 1'b0;
            hs_d.ovr_arm = 1'b0;
        end
        if (f_done) begin
            if (hs_d.rxne) begin
                hs_d.ovr     = 1'b1;
                hs_d.ovr_arm = 1'b0;
            end else begin
                hs_d.rxbuf = f_rx;
                hs_d.rxne  = 1'b1;
            end
            hs_d.bsy = ~hs_d.txe;
        end
        if (!cs_act) hs_d.bsy = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q     <= '0;
            hs_q.txe <= 1'b1;
        end else begin
            hs_q <= hs_d;
        end
    end

    assign rd_data = hs_q.rxbuf;
    assign txe     = hs_q.txe;
    assign rxne    = hs_q.rxne;
    assign bsy     = hs_q.bsy;
    assign ovr     = hs_q.ovr;
endmodule

module spi_tgt_chk #(
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic          f_start,
    input logic          f_done,
    input logic          cs_act,
    input logic          txe,
    input logic          rxne,
    input logic          bsy,
    input logic          ovr,
    input logic [DW-1:0] rd_data
);
    AST_TXE_CLR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !txe); // R3
    AST_TXE_SET_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (f_start && !wr_en) |=> txe); // R3
    AST_RXNE_SET_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        f_done |=> rxne); // R4
    AST_RXNE_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !f_done) |=> !rxne); // R4
    AST_BSY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (f_start && cs_act) |=> bsy); // R5
    AST_BSY_DROP_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !bsy); // R5
    AST_OVR_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> (rd_data == $past(rd_data))); // R7
endmodule

bind spi_tgt_buffered spi_tgt_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .f_start (f_start),
    .f_done  (f_done),
    .cs_act  (cs_act),
    .txe     (txe),
    .rxne    (rxne),
    .bsy     (bsy),
    .ovr     (ovr),
    .rd_data (rd_data)
);

// File: tb/spi_tgt_buffered_bench.sv
module spi_tgt_buffered_bench;
    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b1, cs_n = 1'b1, mosi = 1'b0;
    logic       miso;
    logic       wr_en = 1'b0, rd_en = 1'b0, stat_rd = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       txe, rxne, bsy, ovr;

    int n_cmp = 0;
    int n_bad = 0;

    // reference model state
    logic [7:0] m_txbuf = '0, m_last = '0, m_rx = '0;
    logic       m_txe = 1'b1, m_rxne = 1'b0, m_ovr = 1'b0, m_arm = 1'b0;

    always #10 clk = ~clk;

    spi_tgt_buffered u_spi_tgt_buffered (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .stat_rd(stat_rd), .txe(txe), .rxne(rxne),
        .bsy(bsy), .ovr(ovr)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [7:0] pick_tx();
        return m_txe ? m_last : m_txbuf;
    endfunction

    task automatic host_write(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
        m_txbuf = b; m_txe = 1'b0;
    endtask

    task automatic host_read(input string req);
        @(negedge clk);
        chk(req, rd_data, m_rx);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        m_rxne = 1'b0;
        if (m_ovr) m_arm = 1'b1;
    endtask

    task automatic stat_read();
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        if (m_arm) begin m_ovr = 1'b0; m_arm = 1'b0; end
    endtask

    task automatic check_flags(input string req);
        chk({req, " txe"},  {7'd0, txe},  {7'd0, m_txe});
        chk({req, " rxne"}, {7'd0, rxne}, {7'd0, m_rxne});
        chk({req, " ovr"},  {7'd0, ovr},  {7'd0, m_ovr});
        chk({req, " rd_data"}, rd_data, m_rx);
    endtask

    // one full frame, no idle time before or after; optional mid-frame host access
    task automatic frame(input logic [7:0] mo, input bit do_wr, input logic [7:0] wb,
                         input bit do_rd, input string req);
        logic [7:0] exp_tx, got;
        exp_tx = pick_tx();
        if (!m_txe) begin m_last = m_txbuf; m_txe = 1'b1; end
        for (int b = 7; b >= 0; b--) begin
            @(negedge clk);
            sck = 1'b0; mosi = mo[b];
            wait_clk(H - 1);
            got[b] = miso;
            if (b == 4) chk({req, " R5 bsy mid-frame"}, {7'd0, bsy}, 8'd1);
            if (b == 4 && do_wr) host_write(wb);
            if (b == 4 && do_rd) host_read({req, " R4 mid-frame read"});
            @(negedge clk);
            sck = 1'b1;
            wait_clk(H - 1);
        end
        chk({req, " R1 miso"}, got, exp_tx);
        if (m_rxne) m_ovr = 1'b1;
        else begin m_rx = mo; m_rxne = 1'b1; end
        m_arm = m_ovr ? (m_arm & 1'b0) : m_arm;
        check_flags(req);
        chk({req, " R5 bsy end"}, {7'd0, bsy}, {7'd0, ~m_txe});
    endtask

    task automatic deselect();
        @(negedge clk);
        cs_n = 1'b1;
        wait_clk(6);
    endtask

    task automatic select();
        @(negedge clk);
        cs_n = 1'b0;
        wait_clk(6);
    endtask

    initial begin
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(4);
        // R10 reset state
        chk("R10 txe", {7'd0, txe}, 8'd1);
        chk("R10 rxne", {7'd0, rxne}, 8'd0);
        chk("R10 bsy", {7'd0, bsy}, 8'd0);
        chk("R10 ovr", {7'd0, ovr}, 8'd0);
        chk("R10 rd_data", rd_data, 8'h00);

        // R3 write clears txe; R1 MSB-first exchange; R4 receive
        host_write(8'hF1);
        chk("R3 txe after write", {7'd0, txe}, 8'd0);
        select();
        frame(8'hA1, 1'b0, 8'h00, 1'b0, "R1 first");
        // R5 no pending byte: bsy low; R4 read clears rxne
        host_read("R4 read A1");
        wait_clk(1);
        chk("R4 rxne cleared", {7'd0, rxne}, 8'd0);

        // R6 + R2: load during frame, back-to-back with mid-frame read
        host_write(8'hF2);
        frame(8'hA2, 1'b1, 8'hF3, 1'b0, "R6 load-ahead");
        frame(8'hA3, 1'b0, 8'h00, 1'b1, "R2 back-to-back");
        host_read("R2 read A3");

        // R8 underrun: repeat last byte, txe stays 1
        frame(8'h5C, 1'b0, 8'h00, 1'b0, "R8 repeat");
        chk("R8 txe stays", {7'd0, txe}, 8'd1);

        // R7 overrun: second byte lost, old kept, clear sequence
        frame(8'h3D, 1'b0, 8'h00, 1'b0, "R7 overrun");
        chk("R7 ovr set", {7'd0, ovr}, 8'd1);
        chk("R7 old byte kept", rd_data, 8'h5C);
        stat_read();
        wait_clk(1);
        chk("R7 status alone keeps ovr", {7'd0, ovr}, 8'd1);
        host_read("R7 read old");
        wait_clk(1);
        chk("R7 read alone keeps ovr", {7'd0, ovr}, 8'd1);
        stat_read();
        wait_clk(1);
        chk("R7 cleared", {7'd0, ovr}, 8'd0);

        // R9 abort mid-frame
        host_write(8'h96);
        for (int b = 7; b >= 5; b--) begin
            @(negedge clk); sck = 1'b0; mosi = 1'b1; wait_clk(H - 1);
            @(negedge clk); sck = 1'b1; wait_clk(H - 1);
        end
        m_last = m_txbuf; m_txe = 1'b1;
        deselect();
        chk("R9 rxne unchanged", {7'd0, rxne}, {7'd0, m_rxne});
        chk("R9 rd_data unchanged", rd_data, m_rx);
        chk("R5 bsy after deselect", {7'd0, bsy}, 8'd0);
        select();
        frame(8'h42, 1'b0, 8'h00, 1'b0, "R9 clean restart");
        host_read("R9 read");

        // constrained random, continuous frames
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 40; i++) begin
            logic [7:0] mo, wb;
            bit dw, dr;
            mo = 8'($urandom);
            wb = 8'($urandom);
            dw = ($urandom % 3) != 0;
            dr = ($urandom % 4) != 0 && m_rxne;
            frame(mo, dw, wb, dr, "R2 random");
            if (($urandom % 5) == 0) begin
                host_read("R4 random read");
                stat_read();
            end
        end
        deselect();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule